// File: doc/BRIEF.md
# DRAM Strobe Sequencer for a Multiplexed Four-Clock Bus

This block sits between a processor with a multiplexed address/data bus and a bank of DRAM. It watches the address latch strobe, the bus status, the byte-high-enable line (a refresh line on narrow-bus parts), address bit 0 and the read and write strobes. From these it sorts each bus cycle into a read, a write or a refresh. It then drives a multiplexed row/column address, RAS, CAS and a ready line back to the processor.

The block runs on a clock at twice the processor clock rate. Each rising edge is therefore one half-clock, so the sequence steps on both phases of the processor clock.

A refresh is a read-shaped cycle that carries a fixed pin pattern. The controller answers it with a RAS-only refresh, using the row taken from the bus address. A region select input decides whether the controller takes part in a cycle at all. A parameter sets the number of wait half-clocks inserted through the ready line.

Top module: `dramc_ctl`

## Requirements
- R1: With `BUS8`=0, a cycle with `bus_wr`=0, `bhe_rfsh`=1 and `addr[0]`=1 at acceptance is a refresh. Any other cycle with `bus_wr`=0 is a read.
- R2: With `BUS8`=1, a cycle with `bus_wr`=0, `bhe_rfsh`=0 and `addr[0]`=1 is a refresh. Any other cycle with `bus_wr`=0 is a read.
- R3: A cycle is accepted on the edge that samples `ale`=1 with `dram_sel`=1 while idle. Counting samples after that edge as t=0,1,..., the block behaves as follows. At t=0, `ma` holds the row `addr[2*MA_W-1:MA_W]` and `ras_n`=1. From t=1, `ras_n`=0 with `ma` still holding the row. From t=2 (read and write only), `ma` holds the column `addr[MA_W-1:0]`.
- R4: On a read, `cas_n` goes low at t=3, one half-clock after the column appears.
- R5: On a write, `cas_n` goes low one half-clock after the first edge at t>=2 that samples `wr_n`=0, and never earlier than t=3.
- R6: On a refresh, `ras_n` is low from t=1, `cas_n` stays high for the whole cycle and `ma` keeps the row.
- R7: `ready` is low from t=0 until `WAIT_HC` half-clocks after the sample where CAS is asserted (or where RAS holds, on refresh), and high otherwise.
- R8: Once the wait count has expired, the first edge that samples `rd_n`=1 and `wr_n`=1 raises `ras_n` and `cas_n` together.
- R9: After reset and after every cycle, `ras_n` stays high for at least `PRE_HC`=2 half-clocks. An `ale` arriving during that precharge is ignored.
- R10: A cycle whose `ale` is sampled with `dram_sel`=0 leaves `ras_n` and `cas_n` high and `ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, one rising edge per processor half-clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address latch strobe, high for one half-clock at cycle start |
| bus_wr | input | 1 | Status: 1 marks a write cycle, sampled with `ale` |
| bhe_rfsh | input | 1 | Byte-high-enable (wide bus) or refresh line (narrow bus) |
| dram_sel | input | 1 | 1 when the cycle addresses the DRAM region |
| addr | input | 2*MA_W | Bus address latched with `ale`; bit 0 takes part in refresh decoding |
| rd_n | input | 1 | Read strobe, active low (also active during refresh) |
| wr_n | input | 1 | Write strobe, active low |
| ma | output | MA_W | Multiplexed row/column address to the DRAM |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| ready | output | 1 | 1 lets the processor finish its cycle; 0 inserts waits |

## Verification
Two things can fall on the same edge: the end of a cycle, when the released strobes start the precharge, and the address latch strobe of the next cycle. The bench provokes this in directed and random cycles by pulsing `ale` with `dram_sel`=1 in the first precharge half-clock. It then judges that `ras_n` stays high through the precharge and the idle sample after it. A second pairing comes when the write strobe arrives on the very edge where the column is first presented. Writes with no strobe delay test that CAS still waits one half-clock past the column.

// File: rtl/dramc_pkg.sv
// Package: shared types of the DRAM strobe sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dramc_pkg;

    // Sequencer states, one step per processor half-clock
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_ACT,
        ST_PRE
    } seq_st_e;

    // Bus cycle classes the controller serves
    typedef enum logic [1:0] {
        CY_READ,
        CY_WRITE,
        CY_RFSH
    } cyc_e;

endpackage

// File: rtl/dramc_decode.sv
// Module: dramc_decode
// Sorts a bus cycle into read, write or refresh from the status and the
// byte-high/refresh pin pattern. BUS8 picks the narrow-bus pattern.
// Assumes the inputs are stable while the address latch strobe is high.
module dramc_decode #(
    parameter bit BUS8 = 1'b0
) (
    input  logic             bus_wr,
    input  logic             bhe_rfsh,
    input  logic             a0,
    output dramc_pkg::cyc_e  kind
);
    import dramc_pkg::*;

    logic rf_pat;

    // Refresh pin pattern, chosen by bus width
    generate
        if (BUS8) begin : g_narrow
            assign rf_pat = !bhe_rfsh && a0;
        end else begin : g_wide
            assign rf_pat = bhe_rfsh && a0;
        end
    endgenerate

    // Cycle class: write status wins, then refresh pattern, else read
    always_comb begin
        if (bus_wr)      kind = CY_WRITE;
        else if (rf_pat) kind = CY_RFSH;
        else             kind = CY_READ;
    end

endmodule

// File: rtl/dramc_amux.sv
// Module: dramc_amux
// Latches the bus address at cycle acceptance and presents either its
// upper half (row) or lower half (column) on the DRAM address pins.
// Assumes load is high for exactly the accepting half-clock.
module dramc_amux #(
    parameter int MA_W = 8,
    localparam int ADDR_W = 2 * MA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic              col_sel,
    output logic [MA_W-1:0]   ma
);
    logic [MA_W-1:0] row_q;
    logic [MA_W-1:0] col_q;

    // Capture row and column halves when a cycle is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            row_q <= addr[ADDR_W-1:MA_W];
            col_q <= addr[MA_W-1:0];
        end
    end

    // Drive the half selected by the sequencer
    always_comb begin
        ma = col_sel ? col_q : row_q;
    end

endmodule

// File: rtl/dramc_seq.sv
// Module: dramc_seq
// Strobe state machine: row, RAS, column, CAS, wait count, precharge.
// One step per rising edge of a double-rate clock (one processor
// half-clock). Assumes the processor holds its strobe until ready.
module dramc_seq #(
    parameter int WAIT_HC = 2,
    parameter int PRE_HC  = 2,
    localparam int CNT_MAX = (WAIT_HC > PRE_HC) ? WAIT_HC : PRE_HC,
    localparam int CW      = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale,
    input  logic             dram_sel,
    input  dramc_pkg::cyc_e  kind_in,
    input  logic             rd_n,
    input  logic             wr_n,
    output logic             load,
    output logic             col_sel,
    output logic             ras_n,
    output logic             cas_n,
    output logic             ready
);
    import dramc_pkg::*;

    seq_st_e         st_q;
    cyc_e            kind_q;
    logic [CW-1:0]   cnt_q;
    logic            strobes_off;

    assign strobes_off = rd_n && wr_n;

    // Accept a new cycle only from idle
    always_comb begin
        load = (st_q == ST_IDLE) && ale && dram_sel;
    end

    // State, cycle class and shared wait/precharge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= CY_READ;
            cnt_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (load) begin
                        st_q   <= ST_ROW;
                        kind_q <= kind_in;
                    end
                end
                ST_ROW: st_q <= ST_RAS;
                ST_RAS: begin
                    if (kind_q == CY_RFSH) begin
                        st_q  <= ST_ACT;
                        cnt_q <= CW'(WAIT_HC);
                    end else begin
                        st_q <= ST_COL;
                    end
                end
                ST_COL: begin
                    if (kind_q == CY_READ || !wr_n) begin
                        st_q  <= ST_ACT;
                        cnt_q <= CW'(WAIT_HC);
                    end
                end
                ST_ACT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (strobes_off) begin
                        st_q  <= ST_PRE;
                        cnt_q <= CW'(PRE_HC - 1);
                    end
                end
                ST_PRE: begin
                    if (cnt_q == '0) st_q <= ST_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Strobe, mux and ready decode from the registered state
    always_comb begin
        ras_n   = !(st_q == ST_RAS || st_q == ST_COL || st_q == ST_ACT);
        cas_n   = !(st_q == ST_ACT && kind_q != CY_RFSH);
        col_sel = (st_q == ST_COL) || (st_q == ST_ACT && kind_q != CY_RFSH);
        ready   = !(st_q == ST_ROW || st_q == ST_RAS || st_q == ST_COL ||
                    (st_q == ST_ACT && cnt_q != '0));
    end

endmodule

// File: rtl/dramc_ctl.sv
// Module: dramc_ctl (top)
// Clocked DRAM controller for a processor with a multiplexed four-clock
// bus. Decodes read/write/refresh, sequences RAS/CAS, multiplexes the
// address and inserts wait half-clocks. Assumes clk runs at twice the
// processor clock and that the processor keeps the bus timing rules.
module dramc_ctl #(
    parameter int MA_W    = 8,
    parameter bit BUS8    = 1'b0,
    parameter int WAIT_HC = 2,
    parameter int PRE_HC  = 2,
    localparam int ADDR_W = 2 * MA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              bus_wr,
    input  logic              bhe_rfsh,
    input  logic              dram_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [MA_W-1:0]   ma,
    output logic              ras_n,
    output logic              cas_n,
    output logic              ready
);
    import dramc_pkg::*;

    cyc_e kind;
    logic load;
    logic col_sel;

    dramc_decode #(.BUS8(BUS8)) i_decode (
        .bus_wr   (bus_wr),
        .bhe_rfsh (bhe_rfsh),
        .a0       (addr[0]),
        .kind     (kind)
    );

    dramc_seq #(.WAIT_HC(WAIT_HC), .PRE_HC(PRE_HC)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .dram_sel (dram_sel),
        .kind_in  (kind),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .load     (load),
        .col_sel  (col_sel),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .ready    (ready)
    );

    dramc_amux #(.MA_W(MA_W)) i_amux (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr    (addr),
        .col_sel (col_sel),
        .ma      (ma)
    );

endmodule

// File: rtl/dramc_ctl_chk.sv
// Module: dramc_ctl_chk
// Protocol checks on the DRAM controller's pins, bound into dramc_ctl.
// Assumes the processor holds each strobe until ready has been seen.
module dramc_ctl_chk #(
    parameter int MA_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            dram_sel,
    input logic            rd_n,
    input logic            wr_n,
    input logic [MA_W-1:0] ma,
    input logic            ras_n,
    input logic            cas_n,
    input logic            ready
);

    // R6
    cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R8
    release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n));

    // R9
    min_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    // R3
    row_held_at_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(ma));

    // R4
    col_settled_at_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(ma));

    // R5
    write_cas_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && $past(rd_n)) |-> !$past(wr_n));

    // R7
    wait_at_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !ready);

    // R10
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !dram_sel && ras_n && ready) |=> ras_n);

endmodule

bind dramc_ctl dramc_ctl_chk #(.MA_W(MA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .dram_sel (dram_sel),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ma       (ma),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ready    (ready)
);

// File: tb/test_dramc_ctl.sv
// Bench for dramc_ctl: directed corners plus seeded random bus cycles,
// checked per half-clock against timings computed from the requirements.
module test_dramc_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int MA_W       = 8;
    localparam int ADDR_W     = 2 * MA_W;
    localparam int WAIT_HC    = 2;
    localparam int K_READ     = 0;
    localparam int K_WRITE    = 1;
    localparam int K_RFSH     = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ale, bus_wr, bhe_rfsh, dram_sel, rd_n, wr_n;
    logic [ADDR_W-1:0] addr;
    logic [MA_W-1:0]   ma, ma8;
    logic              ras_n, cas_n, ready;
    logic              ras8_n, cas8_n, ready8;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dramc_ctl #(.MA_W(MA_W), .BUS8(1'b0), .WAIT_HC(WAIT_HC)) i_dramc_ctl (
        .clk(clk), .rst_n(rst_n), .ale(ale), .bus_wr(bus_wr),
        .bhe_rfsh(bhe_rfsh), .dram_sel(dram_sel), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .ma(ma), .ras_n(ras_n),
        .cas_n(cas_n), .ready(ready)
    );

    dramc_ctl #(.MA_W(MA_W), .BUS8(1'b1), .WAIT_HC(WAIT_HC)) i_dramc_ctl_b8 (
        .clk(clk), .rst_n(rst_n), .ale(ale), .bus_wr(bus_wr),
        .bhe_rfsh(bhe_rfsh), .dram_sel(dram_sel), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .ma(ma8), .ras_n(ras8_n),
        .cas_n(cas8_n), .ready(ready8)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected class for a wide (R1) or narrow (R2) bus
    function automatic int kind_of(input bit narrow, input bit wr, input logic bhe, input logic a0);
        if (wr) return K_WRITE;
        if (narrow ? (!bhe && a0) : (bhe && a0)) return K_RFSH;
        return K_READ;
    endfunction

    // Sample index at which CAS (or refresh hold) starts: R4, R5, R6
    function automatic int act_start(input int k, input int w);
        if (k == K_RFSH) return 2;
        if (k == K_READ) return 3;
        return (w + 1 > 3) ? w + 1 : 3;
    endfunction

    task automatic run_cycle(input bit wr, input logic bhe, input logic [ADDR_W-1:0] a,
                             input int w, input int h, input bit pre_ale);
        int k, k8, ta, tr, te;
        bit seen8;
        string ctag;
        k  = kind_of(1'b0, wr, bhe, a[0]);
        k8 = kind_of(1'b1, wr, bhe, a[0]);
        ta = act_start(k, w);
        tr = ta + WAIT_HC;
        te = tr + h + 1;
        ctag = (k == K_RFSH) ? "R6" : (k == K_READ) ? "R4" : "R5";
        seen8 = 1'b0;
        @(negedge clk);
        ale = 1'b1; dram_sel = 1'b1; bus_wr = wr; bhe_rfsh = bhe; addr = a;
        rd_n = wr; wr_n = 1'b1;
        for (int t = 0; t <= te + 3; t++) begin
            @(negedge clk);
            if (!cas8_n) seen8 = 1'b1;
            if (t < te) begin
                chk("R3", ras_n, (t == 0));
                chk(ctag, cas_n, !(k != K_RFSH && t >= ta));
                chk("R7", ready, (t >= ta + WAIT_HC));
                chk((k == K_RFSH) ? "R1" : "R3", ma,
                    (k != K_RFSH && t >= 2) ? a[MA_W-1:0] : a[ADDR_W-1:MA_W]);
            end else begin
                chk((t == te) ? "R8" : "R9", ras_n, 1);
                chk((t == te) ? "R8" : "R9", cas_n, 1);
                chk("R7", ready, 1);
            end
            if (t == 0) ale = 1'b0;
            if (wr && t == w) wr_n = 1'b0;
            if (t == tr + h) begin rd_n = 1'b1; wr_n = 1'b1; end
            if (pre_ale && t == te) ale = 1'b1;
            if (pre_ale && t == te + 1) ale = 1'b0;
        end
        chk("R2", seen8, (k8 != K_RFSH));
        repeat (6) @(negedge clk);
    endtask

    task automatic run_desel(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        ale = 1'b1; dram_sel = 1'b0; bus_wr = 1'b0; addr = a; rd_n = 1'b0;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            chk("R10", ras_n, 1);
            chk("R10", cas_n, 1);
            chk("R10", ready, 1);
            if (t == 0) ale = 1'b0;
        end
        rd_n = 1'b1; dram_sel = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0D4A_11C5));
        rst_n = 1'b0; ale = 1'b0; bus_wr = 1'b0; bhe_rfsh = 1'b0;
        dram_sel = 1'b0; addr = '0; rd_n = 1'b1; wr_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", ras_n, 1);
        chk("R9", cas_n, 1);
        chk("R7", ready, 1);

        run_cycle(1'b0, 1'b0, 16'hA55A, 0, 0, 1'b0);  // plain read
        run_cycle(1'b0, 1'b0, 16'h3C01, 0, 1, 1'b0);  // R2 narrow refresh, wide read
        run_cycle(1'b0, 1'b1, 16'h7E03, 0, 0, 1'b0);  // R1 wide refresh
        run_cycle(1'b0, 1'b1, 16'h1234, 0, 2, 1'b0);  // R1 bhe alone is a read
        run_cycle(1'b1, 1'b1, 16'hBEEF, 0, 0, 1'b0);  // R5 write strobe early
        run_cycle(1'b1, 1'b0, 16'hC0DE, 6, 1, 1'b0);  // R5 late write strobe
        run_cycle(1'b1, 1'b0, 16'h0F0F, 2, 0, 1'b1);  // R9 ale during precharge
        run_desel(16'hFFFF);                          // R10

        for (int i = 0; i < 80; i++) begin
            bit wr;
            wr = ($urandom % 3) == 0;
            run_cycle(wr, 1'($urandom), 16'($urandom), int'($urandom % 7),
                      int'($urandom % 4), wr && ($urandom % 2 == 1));
            if ($urandom % 8 == 0) run_desel(16'($urandom));
        end
        finish_run();
    end

endmodule